// File: doc/BRIEF.md
# Flash Operation Status Byte Generator

This block forms the byte a self-timed flash array returns when the host reads it while a program or erase is running. The host tells it which operation is under way, the bit 7 of the byte being written, which sectors are marked for erase, whether the sector-load window is still open, and whether the internal pulse limit was passed. From these it builds a status byte with a data-polling bit, two read-driven toggle bits, a timeout flag and an erase-started flag. When nothing is running, the array data goes straight through to the output.

The two toggle bits do not run off the clock. Each one flips once for every read access, so a host can tell "busy" from "done" by comparing two reads in a row. One toggle bit counts every read while an algorithm runs. The other counts only reads whose address falls in a sector marked for erase, so that the host can find out which sectors take part in the erase.

Top module: `flash_status_gen`

## Requirements
- R1: With the operation code at 0 (idle), or during reset, the output equals the array data input.
- R2: With the operation code at 1 (byte program), bit 7 of the output is the complement of the written bit 7.
- R3: With the operation code at 2 (erase), bit 7 reads 0. With code 3 (erase suspended), a read in a selected sector returns bit 7 as 1.
- R4: Bit 6 flips once for each rising edge of the read strobe while the code is 1, 2 or 4, whatever the address. A strobe held high for several cycles counts as one read.
- R5: With code 3, bit 6 keeps its value across reads.
- R6: Bit 2 flips once per read only with code 2 or 3, and only when the sector field (the top SECT_W address bits) indexes a set bit of the selected-sector map. Reads of other sectors, and all reads under codes 1 and 4, leave it unchanged.
- R7: A time-limit pulse during code 1, 2 or 4 sets a flag shown on bit 5 under those codes. The flag holds until a reset-command pulse clears it.
- R8: Bit 3 reads as the inverse of the load-window flag under code 2, and reads 0 under codes 1 and 4.
- R9: Both toggle bits clear to 0 when a program starts (entering code 1 or 4 from any other code) and when an erase starts (entering code 2 from idle). Resuming an erase from code 3 or 4 keeps them.
- R10: With code 3, a read outside every selected sector returns the array data.
- R11: The status byte places the polling bit at bit 7, the all-reads toggle at bit 6, the timeout flag at bit 5, the erase-started flag at bit 3 and the sector toggle at bit 2. Bits 4, 1 and 0 read 0, and bit 5 reads 0 under code 3.
- R12: With code 4 (program during erase suspend), bits 7, 6 and 5 behave as under code 1, at any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Current operation: 0 idle, 1 program, 2 erase, 3 erase suspended, 4 suspended program |
| wr_bit7_i | input | 1 | Bit 7 of the byte being programmed |
| sect_sel_i | input | 2**SECT_W | One bit per sector, set when the sector is marked for erase |
| load_win_i | input | 1 | High while further sector addresses may still be loaded |
| time_lim_i | input | 1 | Pulse: internal pulse count exceeded its limit |
| rst_cmd_i | input | 1 | Pulse: reset command written, clears the timeout flag |
| rd_i | input | 1 | Read strobe; each rising edge is one read access |
| rd_addr_i | input | ADDR_W | Read address |
| arr_data_i | input | 8 | Array data for pass-through reads |
| status_o | output | 8 | Returned byte |

## Verification
Directed sequences walk through each operation code in turn. They read inside and outside the selected sectors to separate the all-reads toggle from the sector toggle, hold a strobe high over several cycles to show that one access flips a toggle only once, and move between suspend and resume to tell a new start, which clears the toggles, from a resume, which keeps them. A seeded random phase then mixes operation changes, reads at random addresses, changes to the sector map and window flag, and timeout and reset pulses. A bench model predicts every byte, so wrong bit placement, a toggle driven by the clock instead of the strobe, or a lost timeout latch each show up as a byte mismatch.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_PROG  = 3'd1,
    OP_ERASE = 3'd2,
    OP_ESUSP = 3'd3,
    OP_SPROG = 3'd4
  } fop_e;

  // algorithm actively running: all-reads toggle advances, timeout shown
  function automatic logic op_running(input logic [2:0] op);
    return (op == OP_PROG) || (op == OP_ERASE) || (op == OP_SPROG);
  endfunction

  // program-like codes: polling bit is the inverted written bit
  function automatic logic op_programming(input logic [2:0] op);
    return (op == OP_PROG) || (op == OP_SPROG);
  endfunction

  // erase active or suspended: sector toggle may advance
  function automatic logic op_erase_side(input logic [2:0] op);
    return (op == OP_ERASE) || (op == OP_ESUSP);
  endfunction

  // a fresh operation begins (resume is not a start)
  function automatic logic op_starts(input logic [2:0] nxt, input logic [2:0] prv);
    if (nxt == prv) return 1'b0;
    if (nxt == OP_PROG || nxt == OP_SPROG) return 1'b1;
    return (nxt == OP_ERASE) && (prv == OP_IDLE);
  endfunction

  // fixed bit layout of the status byte
  function automatic logic [7:0] pack_status(input logic poll, input logic tg_all,
                                             input logic tmo, input logic ers_go,
                                             input logic tg_sec);
    return {poll, tg_all, tmo, 1'b0, ers_go, tg_sec, 2'b00};
  endfunction

endpackage

// File: rtl/fsg_strobe_edge.sv
module fsg_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic rise_o
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_i;
  end

  assign rise_o = strobe_i & ~strobe_q;

  // R4
  one_rise_per_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/fsg_toggle_reg.sv
module fsg_toggle_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic flip_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (clr_i)  q_o <= 1'b0;
    else if (flip_i) q_o <= ~q_o;
  end

  // R9
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !q_o);
  // R4
  flip_inverts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flip_i && !clr_i) |=> (q_o != $past(q_o)));
  // R5
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flip_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/fsg_fault_latch.sv
module fsg_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end

  // R7
  fault_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> q_o);
  // R7
  fault_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !q_o);
  // R7
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/fsg_sector_hit.sv
module fsg_sector_hit #(
  parameter int ADDR_W = 19,
  parameter int SECT_W = 3
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [(1<<SECT_W)-1:0] sel_i,
  output logic                   hit_o
);
  localparam int NSECT = 1 << SECT_W;

  logic [SECT_W-1:0] sect_idx;
  logic [NSECT-1:0]  idx_onehot;

  assign sect_idx = addr_i[ADDR_W-1 -: SECT_W];

  for (genvar s = 0; s < NSECT; s++) begin : g_dec
    assign idx_onehot[s] = (sect_idx == SECT_W'(s));
  end

  assign hit_o = |(idx_onehot & sel_i);

  logic unused_low;
  assign unused_low = ^addr_i[ADDR_W-SECT_W-1:0];

  // R6
  decode_onehot_chk: assert final ($onehot0(idx_onehot));
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int SECT_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             op_i,
  input  logic                   wr_bit7_i,
  input  logic [(1<<SECT_W)-1:0] sect_sel_i,
  input  logic                   load_win_i,
  input  logic                   time_lim_i,
  input  logic                   rst_cmd_i,
  input  logic                   rd_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  input  logic [7:0]             arr_data_i,
  output logic [7:0]             status_o
);
  logic [2:0] op_q;
  logic       rd_rise;
  logic       sect_hit;
  logic       op_start;
  logic       flip_all, flip_sec;
  logic       tog_all, tog_sec;
  logic       tmo_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) op_q <= OP_IDLE;
    else        op_q <= op_i;
  end

  assign op_start = op_starts(op_i, op_q);
  assign flip_all = rd_rise & op_running(op_i);
  assign flip_sec = rd_rise & op_erase_side(op_i) & sect_hit;

  fsg_strobe_edge u_edge (
    .clk(clk), .rst_n(rst_n), .strobe_i(rd_i), .rise_o(rd_rise));

  fsg_sector_hit #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_hit (
    .addr_i(rd_addr_i), .sel_i(sect_sel_i), .hit_o(sect_hit));

  fsg_toggle_reg u_tog_all (
    .clk(clk), .rst_n(rst_n), .clr_i(op_start), .flip_i(flip_all), .q_o(tog_all));

  fsg_toggle_reg u_tog_sec (
    .clk(clk), .rst_n(rst_n), .clr_i(op_start), .flip_i(flip_sec), .q_o(tog_sec));

  fsg_fault_latch u_tmo (
    .clk(clk), .rst_n(rst_n), .set_i(time_lim_i & op_running(op_i)),
    .clr_i(rst_cmd_i), .q_o(tmo_flag));

  always_comb begin
    status_o = arr_data_i;
    if (rst_n) begin
      unique case (op_i)
        OP_PROG, OP_SPROG: status_o = pack_status(~wr_bit7_i, tog_all, tmo_flag, 1'b0, tog_sec);
        OP_ERASE:          status_o = pack_status(1'b0, tog_all, tmo_flag, ~load_win_i, tog_sec);
        OP_ESUSP:          if (sect_hit) status_o = pack_status(1'b1, tog_all, 1'b0, 1'b0, tog_sec);
        default:           status_o = arr_data_i;
      endcase
    end
  end

  // R3
  erase_poll_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ERASE) |-> !status_o[7]);
  // R11
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_running(op_i) |-> (status_o[4] == 1'b0 && status_o[1:0] == 2'b00));
  // R5
  suspend_all_toggle_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ESUSP && !op_start) |=> $stable(tog_all));
endmodule

// File: tb/flash_status_gen_tb_top.sv
module flash_status_gen_tb_top;
  localparam int AW = 19;
  localparam int SW = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, wr_bit7, load_win, time_lim, rst_cmd, rd;
  logic [2:0]    op;
  logic [7:0]    sel, arr, status;
  logic [AW-1:0] addr;

  flash_status_gen #(.ADDR_W(AW), .SECT_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op), .wr_bit7_i(wr_bit7), .sect_sel_i(sel),
    .load_win_i(load_win), .time_lim_i(time_lim), .rst_cmd_i(rst_cmd), .rd_i(rd),
    .rd_addr_i(addr), .arr_data_i(arr), .status_o(status));

  int n_chk = 0;
  int n_fail = 0;
  logic m_t6 = 1'b0, m_t2 = 1'b0, m_q5 = 1'b0;

  function automatic logic is_run(input logic [2:0] o);
    return o == 3'd1 || o == 3'd2 || o == 3'd4;
  endfunction

  function automatic logic in_sel(input logic [AW-1:0] a);
    return sel[a[AW-1 -: SW]];
  endfunction

  function automatic logic [7:0] exp_byte(input logic [AW-1:0] a);
    logic [7:0] b;
    b = arr;
    case (op)
      3'd1, 3'd4: begin b = 8'h00; b[7] = ~wr_bit7; b[6] = m_t6; b[5] = m_q5; b[2] = m_t2; end
      3'd2:       begin b = 8'h00; b[6] = m_t6; b[5] = m_q5; b[3] = ~load_win; b[2] = m_t2; end
      3'd3:       if (in_sel(a)) begin b = 8'h00; b[7] = 1'b1; b[6] = m_t6; b[2] = m_t2; end
      default:    b = arr;
    endcase
    return b;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic set_op(input logic [2:0] nxt);
    logic st;
    st = (nxt != op) && (nxt == 3'd1 || nxt == 3'd4 || (nxt == 3'd2 && op == 3'd0));
    if (st) begin m_t6 = 1'b0; m_t2 = 1'b0; end
    op = nxt;
    @(negedge clk);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int hold, input string req);
    addr = a;
    rd = 1'b1;
    if (is_run(op)) m_t6 = ~m_t6;
    if ((op == 3'd2 || op == 3'd3) && in_sel(a)) m_t2 = ~m_t2;
    for (int i = 0; i < hold; i++) @(negedge clk);
    check(req, status, exp_byte(a));
    rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_tlim();
    time_lim = 1'b1;
    if (is_run(op)) m_q5 = 1'b1;
    @(negedge clk);
    time_lim = 1'b0;
  endtask

  task automatic pulse_rcmd();
    rst_cmd = 1'b1;
    m_q5 = 1'b0;
    @(negedge clk);
    rst_cmd = 1'b0;
  endtask

  function automatic logic [AW-1:0] addr_in(input int s);
    return {3'(s), 16'(($urandom % 65536))};
  endfunction

  initial begin
    #(20 * 190000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; op = 3'd0; wr_bit7 = 1'b0; load_win = 1'b1; time_lim = 1'b0;
    rst_cmd = 1'b0; rd = 1'b0; sel = 8'h00; arr = 8'h5A; addr = '0;
    repeat (3) @(negedge clk);
    check("R1 reset pass-through", status, 8'h5A);
    rst_n = 1'b1;
    @(negedge clk);
    arr = 8'hC3;
    do_read(addr_in(1), 1, "R1 idle read");
    check("R1 idle value", status, 8'hC3);

    // program: complement of bit 7, toggle per read
    wr_bit7 = 1'b1;
    set_op(3'd1);
    do_read(addr_in(0), 1, "R2 R9 first program read");
    check("R2 R11 program byte", status, 8'h40);
    do_read(addr_in(6), 1, "R4 second program read");
    check("R4 toggled back", status, 8'h00);
    do_read(addr_in(2), 4, "R4 held strobe one flip");
    pulse_tlim();
    do_read(addr_in(3), 1, "R7 timeout shown");
    check("R7 bit5 set", status[5], 1'b1);
    do_read(addr_in(3), 1, "R7 timeout sticky");
    pulse_rcmd();
    do_read(addr_in(3), 1, "R7 cleared by reset command");

    // erase with sector 2 selected
    set_op(3'd0);
    sel = 8'b0000_0100; load_win = 1'b1;
    set_op(3'd2);
    do_read(addr_in(2), 1, "R3 R6 R8 R9 erase selected read");
    check("R11 erase byte layout", status, 8'h44);
    do_read(addr_in(5), 1, "R6 unselected leaves sector toggle");
    check("R6 sector toggle held", status, 8'h04);
    load_win = 1'b0;
    do_read(addr_in(5), 1, "R8 erase started");
    pulse_tlim();
    do_read(addr_in(2), 1, "R7 R11 erase timeout");

    // suspend
    set_op(3'd3);
    do_read(addr_in(2), 1, "R3 R5 R6 suspended selected");
    do_read(addr_in(2), 1, "R5 all toggle held in suspend");
    arr = 8'h81;
    do_read(addr_in(7), 1, "R10 suspended unselected returns array");
    check("R10 array value", status, 8'h81);

    // program during suspend, then resume
    wr_bit7 = 1'b0;
    set_op(3'd4);
    do_read(addr_in(2), 1, "R12 R9 suspended program");
    do_read(addr_in(4), 1, "R12 R6 suspended program any address");
    set_op(3'd2);
    do_read(addr_in(2), 1, "R9 resume keeps toggles");
    pulse_rcmd();

    // constrained random mix
    for (int it = 0; it < 600; it++) begin
      case ($urandom % 9)
        0: set_op(3'($urandom % 5));
        1, 2: do_read({3'($urandom % 8), 16'($urandom % 65536)}, 1 + ($urandom % 3), "R4 R6 random read");
        3: do_read(addr_in($urandom % 2 == 0 ? 2 : 5), 1, "R6 R10 random sector read");
        4: begin sel = 8'($urandom); wr_bit7 = 1'($urandom); load_win = 1'($urandom); arr = 8'($urandom); @(negedge clk); end
        5: pulse_tlim();
        6: if ($urandom % 3 == 0) pulse_rcmd(); else @(negedge clk);
        7: do_read(addr_in(3), 1, "R3 R12 random read");
        default: do_read(addr_in($urandom % 8), 2, "R2 R8 random held read");
      endcase
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule